// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Lane

This block is one 32-bit slice of a vector multiply-accumulate datapath. It takes two packed 32-bit source words and a 32-bit signed accumulator. It multiplies the matching elements of the two sources, adds the products together, and adds that total to the accumulator. The whole fused operation gives exactly the result of running the separate multiply-pairs, widen and accumulate steps one after another.

Two element formats are supported. In byte mode the lane forms four products, each of an unsigned byte from source A and a signed byte from source B. In word mode it forms two signed 16x16 products. A saturate control picks the final 32-bit result: either the low 32 bits of the exact sum (wrapping), or that sum clamped to the signed 32-bit range. A wide vector unit places many lanes side by side. The lane has no handshake. An operation enters on any cycle where `in_valid` is high, and its result appears two cycles later with `res_valid`.

Top module: `dpa_lane`

## Requirements
- R1: With `mode_word` = 0, the exact sum is `acc_in` plus the sum over k = 0..3 of unsigned(`src_a[8k+7:8k]`) times signed(`src_b[8k+7:8k]`). Both operands are treated as signed 32-bit integers.
- R2: With `mode_word` = 1, the exact sum is `acc_in` plus the sum over k = 0..1 of signed(`src_a[16k+15:16k]`) times signed(`src_b[16k+15:16k]`).
- R3: With `sat_en` = 0, `res_data` is the exact sum modulo 2^32, even when the sum lies outside the signed 32-bit range.
- R4: With `sat_en` = 1 and an exact sum above 2147483647, `res_data` is 0x7FFF_FFFF.
- R5: With `sat_en` = 1 and an exact sum below -2147483648, `res_data` is 0x8000_0000.
- R6: With `sat_en` = 1, saturation is decided on the exact sum. An in-range sum is returned unchanged, even when the product total alone lies outside the 32-bit range.
- R7: `res_valid` goes high exactly two clock cycles after the cycle in which `in_valid` was sampled high. Back-to-back operations give back-to-back results, in issue order.
- R8: While `rst_n` is low, and for the cycles of synchronous release after it, `res_valid` is 0.
- R9: When no result is produced, `res_data` keeps the last result it showed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the lane |
| in_valid | input | 1 | Operation present on the source inputs this cycle |
| src_a | input | 32 | Packed source A (unsigned bytes, or signed words) |
| src_b | input | 32 | Packed source B (signed bytes or signed words) |
| acc_in | input | 32 | Signed accumulator addend |
| mode_word | input | 1 | 0 = four byte pairs, 1 = two 16-bit pairs |
| sat_en | input | 1 | 1 = clamp the result to the signed 32-bit range, 0 = wrap |
| res_valid | output | 1 | `res_data` holds a new result |
| res_data | output | 32 | Accumulated dot-product result |

## Verification
The hardest case to reach from the ports is a product total that overflows 32 bits while the accumulator pulls the exact sum back into range. A design that detects overflow in stages would clamp this case wrongly. Random operands almost never produce it, so the stimulus builds it on purpose. It uses word pairs of 0x8000 times 0x8000, whose two products total exactly 2^31, together with a small negative accumulator. It also pairs all-0xFF byte sources with accumulators a few counts from either 32-bit limit, with and without saturation. A scoreboard queue checks every result against an integer model, along with the cycle in which that result appears.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned N_BYTE = LANE_W / BYTE_W;
  localparam int unsigned N_WORD = LANE_W / WORD_W;
  // a product slot must hold a full signed word product plus a sign guard
  localparam int unsigned PROD_W = 2 * WORD_W + 1;
  // room for N_BYTE product slots plus the accumulator
  localparam int unsigned SUM_W  = PROD_W + $clog2(N_BYTE) + 1;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_WORD = 1'b1
  } dpa_mode_e;

  typedef logic signed [PROD_W-1:0] prod_t;
endpackage

// File: rtl/dpa_rst_sync.sv
module dpa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/dpa_prod_stage.sv
module dpa_prod_stage
  import dpa_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANE_W-1:0]        src_a,
  input  logic [LANE_W-1:0]        src_b,
  input  logic [LANE_W-1:0]        acc_in,
  input  dpa_mode_e                mode,
  input  logic                     sat_en,
  output logic                     s1_valid,
  output prod_t [N_BYTE-1:0]       s1_prod,
  output logic [LANE_W-1:0]        s1_acc,
  output logic                     s1_sat
);
  localparam int unsigned BP_W = 2 * BYTE_W + 1;
  localparam int unsigned WP_W = 2 * WORD_W;
  localparam int BP_MAX = (2 ** BYTE_W - 1) * (2 ** (BYTE_W - 1) - 1);
  localparam int BP_MIN = -((2 ** BYTE_W - 1) * (2 ** (BYTE_W - 1)));

  logic signed [BP_W-1:0] byte_p [N_BYTE];
  logic signed [WP_W-1:0] word_p [N_WORD];
  prod_t [N_BYTE-1:0]     prod_d;

  // byte lanes: unsigned A times signed B
  for (genvar gi = 0; gi < N_BYTE; gi++) begin : g_byte
    logic signed [BP_W-1:0] a_ext;
    logic signed [BP_W-1:0] b_ext;
    assign a_ext = {{(BP_W-BYTE_W){1'b0}}, src_a[gi*BYTE_W +: BYTE_W]};
    assign b_ext = {{(BP_W-BYTE_W){src_b[gi*BYTE_W+BYTE_W-1]}},
                    src_b[gi*BYTE_W +: BYTE_W]};
    assign byte_p[gi] = a_ext * b_ext;
  end

  // word lanes: signed A times signed B
  for (genvar gj = 0; gj < N_WORD; gj++) begin : g_word
    logic signed [WP_W-1:0] a_ext;
    logic signed [WP_W-1:0] b_ext;
    assign a_ext = {{(WP_W-WORD_W){src_a[gj*WORD_W+WORD_W-1]}},
                    src_a[gj*WORD_W +: WORD_W]};
    assign b_ext = {{(WP_W-WORD_W){src_b[gj*WORD_W+WORD_W-1]}},
                    src_b[gj*WORD_W +: WORD_W]};
    assign word_p[gj] = a_ext * b_ext;
  end

  // slot selection: word products occupy the low slots, upper slots zero
  for (genvar gk = 0; gk < N_BYTE; gk++) begin : g_sel
    if (gk < N_WORD) begin : g_shared
      always_comb begin
        if (mode == MODE_WORD) begin
          prod_d[gk] = {{(PROD_W-WP_W){word_p[gk][WP_W-1]}}, word_p[gk]};
        end else begin
          prod_d[gk] = {{(PROD_W-BP_W){byte_p[gk][BP_W-1]}}, byte_p[gk]};
        end
      end
    end else begin : g_byte_only
      always_comb begin
        if (mode == MODE_WORD) begin
          prod_d[gk] = '0;
        end else begin
          prod_d[gk] = {{(PROD_W-BP_W){byte_p[gk][BP_W-1]}}, byte_p[gk]};
        end
      end
    end
  end

  logic valid_d;
  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= valid_d;
    end
  end

  // datapath registers: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_prod <= prod_d;
      s1_acc  <= acc_in;
      s1_sat  <= sat_en;
    end
  end

  // R2: word mode leaves the upper product slot empty
  assert_word_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_WORD) |=> (s1_prod[N_BYTE-1] == '0));

  // R1: each byte-mode product stays inside unsigned x signed byte range
  for (genvar ga = 0; ga < N_BYTE; ga++) begin : g_chk
    assert_byte_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == MODE_BYTE) |=>
        ($signed(s1_prod[ga]) <= BP_MAX && $signed(s1_prod[ga]) >= BP_MIN));
  end
endmodule

// File: rtl/dpa_acc_stage.sv
module dpa_acc_stage
  import dpa_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_valid,
  input  prod_t [N_BYTE-1:0]  s1_prod,
  input  logic [LANE_W-1:0]   s1_acc,
  input  logic                s1_sat,
  output logic                res_valid,
  output logic [LANE_W-1:0]   res_data
);
  localparam logic signed [SUM_W-1:0] SAT_HI =
    {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO =
    {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] CLAMP_HI = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] CLAMP_LO = {1'b1, {(LANE_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum_full;
  logic                    over_hi;
  logic                    over_lo;
  logic [LANE_W-1:0]       res_d;

  // exact sum of all slots and the accumulator
  always_comb begin
    sum_full = {{(SUM_W-LANE_W){s1_acc[LANE_W-1]}}, s1_acc};
    for (int i = 0; i < N_BYTE; i++) begin
      sum_full = sum_full +
        {{(SUM_W-PROD_W){s1_prod[i][PROD_W-1]}}, s1_prod[i]};
    end
  end

  assign over_hi = (sum_full > SAT_HI);
  assign over_lo = (sum_full < SAT_LO);

  always_comb begin
    res_d = sum_full[LANE_W-1:0];
    if (s1_sat) begin
      if (over_hi) begin
        res_d = CLAMP_HI;
      end else if (over_lo) begin
        res_d = CLAMP_LO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      res_data <= res_d;
    end
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_sat) |=> (res_data == $past(sum_full[LANE_W-1:0])));

  assert_clamp_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_sat && sum_full > SAT_HI) |=> (res_data == CLAMP_HI));

  assert_clamp_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_sat && sum_full < SAT_LO) |=> (res_data == CLAMP_LO));

  assert_exact_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_sat && sum_full <= SAT_HI && sum_full >= SAT_LO) |=>
      (res_data == $past(sum_full[LANE_W-1:0])));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(res_data));
endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LANE_W-1:0] src_a,
  input  logic [LANE_W-1:0] src_b,
  input  logic [LANE_W-1:0] acc_in,
  input  logic              mode_word,
  input  logic              sat_en,
  output logic              res_valid,
  output logic [LANE_W-1:0] res_data
);
  logic               rst_n_sync;
  logic               s1_valid;
  prod_t [N_BYTE-1:0] s1_prod;
  logic [LANE_W-1:0]  s1_acc;
  logic               s1_sat;
  dpa_mode_e          mode;

  assign mode = dpa_mode_e'(mode_word);

  dpa_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dpa_prod_stage prod_stage_i (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_valid (in_valid),
    .src_a    (src_a),
    .src_b    (src_b),
    .acc_in   (acc_in),
    .mode     (mode),
    .sat_en   (sat_en),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_acc   (s1_acc),
    .s1_sat   (s1_sat)
  );

  dpa_acc_stage acc_stage_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .s1_valid  (s1_valid),
    .s1_prod   (s1_prod),
    .s1_acc    (s1_acc),
    .s1_sat    (s1_sat),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    res_valid == $past(s1_valid));

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n_sync |-> !res_valid);
endmodule

// File: tb/dpa_lane_tb_top.sv
`timescale 1ns/1ps
module dpa_lane_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] acc_in;
  logic        mode_word;
  logic        sat_en;
  logic        res_valid;
  logic [31:0] res_data;

  int total_checks;
  int fail_checks;
  int cyc;
  bit done;
  bit live;

  logic [31:0] exp_q[$];
  int          iss_q[$];
  string       tag_q[$];

  dpa_lane dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .acc_in    (acc_in),
    .mode_word (mode_word),
    .sat_en    (sat_en),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total_checks++;
    if (!ok) begin
      fail_checks++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // integer model of the lane (R1..R6)
  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] acc, input bit mw, input bit sat,
                       output logic [31:0] r, output string tag);
    longint s;
    longint hi;
    longint lo;
    hi = 64'sd2147483647;
    lo = -64'sd2147483648;
    s = longint'($signed(acc));
    if (!mw) begin
      for (int i = 0; i < 4; i++)
        s += longint'(a[8*i +: 8]) * longint'($signed(b[8*i +: 8]));
      tag = "R1";
    end else begin
      for (int i = 0; i < 2; i++)
        s += longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
      tag = "R2";
    end
    r = s[31:0];
    if (sat && s > hi) begin
      r = 32'h7FFF_FFFF; tag = "R4";
    end else if (sat && s < lo) begin
      r = 32'h8000_0000; tag = "R5";
    end else if (sat) begin
      tag = "R6";
    end else if (s > hi || s < lo) begin
      tag = "R3";
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] acc, input bit mw, input bit sat);
    logic [31:0] r;
    string tag;
    @(negedge clk);
    src_a = a; src_b = b; acc_in = acc; mode_word = mw; sat_en = sat;
    in_valid = 1'b1;
    model(a, b, acc, mw, sat, r, tag);
    exp_q.push_back(r);
    iss_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = $urandom; src_b = $urandom; acc_in = $urandom;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected result", res_data, 32'h0);
      end else begin
        logic [31:0] e;
        int is;
        string t;
        e = exp_q.pop_front();
        is = iss_q.pop_front();
        t = tag_q.pop_front();
        check(res_data === e, t, res_data, e);
        check(cyc == is + 2, "R7 latency", cyc, is + 2);
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total_checks++;
      fail_checks++;
      $display("FAIL R7 watchdog: actual no completion, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    cyc = 0; total_checks = 0; fail_checks = 0; done = 1'b0; live = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    src_a = '0; src_b = '0; acc_in = '0; mode_word = 1'b0; sat_en = 1'b0;

    // R8: idle during reset and synchronous release
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(res_valid === 1'b0, "R8 in reset", {31'b0, res_valid}, 32'h0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(res_valid === 1'b0, "R8 after release", {31'b0, res_valid}, 32'h0);
    end
    live = 1'b1;

    // R1 byte mode basics
    issue(32'h0403_0201, 32'h0101_0101, 32'd100, 1'b0, 1'b0);
    issue(32'hFFFF_FFFF, 32'h8080_8080, 32'd0, 1'b0, 1'b0);
    issue(32'hFFFF_FFFF, 32'h7F7F_7F7F, 32'hFFFF_FFFF, 1'b0, 1'b1);
    // R2 word mode basics
    issue(32'h0002_FFFF, 32'h0003_0005, 32'd7, 1'b1, 1'b0);
    issue(32'h8000_8000, 32'h8000_8000, 32'd0, 1'b1, 1'b0); // R3 wrap to 0x80000000
    // R4 positive clamp
    issue(32'hFFFF_FFFF, 32'h7F7F_7F7F, 32'h7FFF_FFF0, 1'b0, 1'b1);
    issue(32'h8000_8000, 32'h8000_8000, 32'd0, 1'b1, 1'b1);
    // R5 negative clamp
    issue(32'hFFFF_FFFF, 32'h8080_8080, 32'h8000_0010, 1'b0, 1'b1);
    issue(32'h8000_7FFF, 32'h7FFF_8000, 32'h8000_0000, 1'b1, 1'b1);
    // R3 wrap without saturation near both limits
    issue(32'hFFFF_FFFF, 32'h7F7F_7F7F, 32'h7FFF_FFF0, 1'b0, 1'b0);
    issue(32'hFFFF_FFFF, 32'h8080_8080, 32'h8000_0010, 1'b0, 1'b0);
    // R6 exact decision: products reach 2^31, accumulator pulls back in range
    issue(32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFB, 1'b1, 1'b1);
    issue(32'hFFFF_FFFF, 32'h7F7F_7F7F, 32'h7FFF_FFFF - 32'd129540, 1'b0, 1'b1);
    idle(4);

    // R9: output holds while idle
    held = res_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = $urandom; src_b = $urandom; acc_in = $urandom;
      check(res_data === held && res_valid === 1'b0, "R9 hold", res_data, held);
    end

    // random mix with gaps, accumulators often near the limits
    for (int n = 0; n < 400; n++) begin
      logic [31:0] acc;
      case ($urandom % 4)
        0: acc = 32'h7FFF_FFFF - ($urandom % 70000);
        1: acc = 32'h8000_0000 + ($urandom % 70000);
        default: acc = $urandom;
      endcase
      issue($urandom, $urandom, acc, 1'($urandom), 1'($urandom));
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    idle(5);
    check(exp_q.size() == 0, "R7 all results returned", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule